// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the slave side of a two-wire serial bus for a byte-wide memory. It oversamples the bus clock and data lines on the system clock and detects start and stop conditions. It then receives a select byte, compares the three chip-enable bits in that byte with the strap inputs, and, for a write, collects a two-byte address followed by data bytes. For a read, it fetches bytes from the back end and shifts them out. The data line is never driven high. The block only asserts an output enable that pulls the line low, for acknowledges and for read bits that are zero.

Toward the memory back end it presents a 15-bit address and a strobe with a byte for each accepted write. It also presents a strobe for each byte it loads for reading, a flag that selects either the main array or a separate identification page, a pulse for every stop condition, and a commit pulse that starts the internal write. The back end returns a busy flag while it writes. While that flag is high, the front end ignores new transfers.

A write-protect input lets the select and address bytes through but refuses every data byte. A repeated start in the middle of a transfer begins a new select byte at once. This is how a random read sets the address with a write select and then turns around into a read.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high starts select-byte reception. A rising data line while the clock is high ends the transfer, returns the block to idle and pulses `stop_o` for one cycle.
- R2: Bits are sampled on the rising clock edge, most significant bit first.
- R3: The select byte is acknowledged only when bits 7..4 are 1010 or 1011 and bits 3..1 equal `ce_strap_i`. On a mismatch, no acknowledge is given and the block ignores all bytes until the next start.
- R4: Select bit 0 is 1 for a read and 0 for a write. Prefix 1011 drives `id_sel_o` high and prefix 1010 drives it low.
- R5: After a write select, two address bytes follow, high byte first, and both are acknowledged. Only the low 15 bits are kept. Each data byte is acknowledged and gives one `wr_strobe_o` pulse carrying `addr_o` and `wr_data_o`.
- R6: The address advances by one after each written or read byte and wraps from 0x7FFF to 0x0000.
- R7: While `wp_i` is high, select and address bytes are still acknowledged, but data bytes are not acknowledged and raise no strobe.
- R8: After a read select, `rd_req_o` pulses once for each byte and `rd_data_i` is sent most significant bit first. A master acknowledge fetches the next byte. A master no-acknowledge releases the line and returns the block to idle.
- R9: While `wr_busy_i` is high, start conditions are ignored and nothing is acknowledged.
- R10: `commit_o` pulses together with `stop_o` only when at least one data byte was accepted since the last start.
- R11: A repeated start without a stop restarts select-byte reception and keeps the current address.
- R12: `sda_oe_o` is low after reset and changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| ce_strap_i | input | 3 | Chip-enable strap value |
| wp_i | input | 1 | Write protect, high refuses data bytes |
| wr_busy_i | input | 1 | Back end internal write in progress |
| rd_data_i | input | 8 | Read byte for `addr_o`, valid while `rd_req_o` is high |
| sda_oe_o | output | 1 | Pull the data line low when high |
| addr_o | output | 15 | Current byte address |
| wr_data_o | output | 8 | Write byte, valid with `wr_strobe_o` |
| wr_strobe_o | output | 1 | One-cycle write-byte strobe |
| rd_req_o | output | 1 | One-cycle read-byte fetch strobe |
| id_sel_o | output | 1 | High selects the identification page |
| stop_o | output | 1 | One-cycle stop-condition pulse |
| commit_o | output | 1 | One-cycle request to start the internal write |

## Verification
A wrong bit count or phase state shows up at the ports on the very next ninth clock. An acknowledge appears where none is due, or a byte is missing from the strobe log, so every transfer in the sweeps exposes it within one byte time. A stale address register shows up in the address carried by the next strobe or the next read byte, most sharply across the 0x7FFF wrap. A lost write-seen flag shows up as a missing or extra commit pulse at the following stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } phase_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], din[g]};
        end
        assign dout[g]  = chain[STAGES-1];
        assign dprev[g] = chain[STAGES];
    end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic scl,
    input  logic scl_p,
    input  logic sda,
    input  logic sda_p,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    always_comb begin
        scl_rise = scl & ~scl_p;
        scl_fall = ~scl & scl_p;
        start_ev = scl & scl_p & sda_p & ~sda;
        stop_ev  = scl & scl_p & ~sda_p & sda;
    end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
    parameter int ADDR_W = 15,
    parameter int CE_W   = 3,
    parameter logic [6-CE_W:0] MAIN_CODE = 4'b1010,
    parameter logic [6-CE_W:0] ID_CODE   = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   ce_strap_i,
    input  logic              wp_i,
    input  logic              wr_busy_i,
    input  logic [7:0]        rd_data_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_strobe_o,
    output logic              rd_req_o,
    output logic              id_sel_o,
    output logic              stop_o,
    output logic              commit_o
);
    import i2cs_pkg::*;

    localparam int BITS_LAST = 7;
    localparam int ACK_SLOT  = 8;
    localparam int ACK_END   = 9;

    typedef struct packed {
        phase_e              st;
        phase_e              nxt;
        logic [3:0]          bitc;
        logic [7:0]          sh;
        logic                oe;
        logic                ack;
        logic                id;
        logic                wrote;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wdat;
        logic                wstb;
        logic                rreq;
        logic                stp;
        logic                cmt;
    } regs_t;

    logic [1:0] sync_now, sync_prev;
    logic       scl_s, sda_s, scl_p, sda_p;
    logic       start_ev, stop_ev, scl_rise, scl_fall;

    i2cs_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (sync_now),
        .dprev (sync_prev)
    );

    assign {scl_s, sda_s} = sync_now;
    assign {scl_p, sda_p} = sync_prev;

    i2cs_cond u_cond (
        .scl      (scl_s),
        .scl_p    (scl_p),
        .sda      (sda_s),
        .sda_p    (sda_p),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    regs_t q, d;
    logic [7:0] byte_b;
    logic       code_main, code_id, ce_hit;

    always_comb begin
        d        = q;
        d.wstb   = 1'b0;
        d.rreq   = 1'b0;
        d.stp    = 1'b0;
        d.cmt    = 1'b0;
        byte_b   = {q.sh[6:0], sda_s};
        code_main = (byte_b[7:CE_W+1] == MAIN_CODE);
        code_id   = (byte_b[7:CE_W+1] == ID_CODE);
        ce_hit    = (byte_b[CE_W:1] == ce_strap_i);

        // advance the address one cycle after each byte strobe
        if (q.wstb || q.rreq) d.addr = q.addr + 1'b1;

        if (stop_ev) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.stp   = 1'b1;
            d.cmt   = q.wrote;
            d.wrote = 1'b0;
        end else if (start_ev && !wr_busy_i) begin
            d.st    = ST_DEV;
            d.nxt   = ST_DEV;
            d.bitc  = '0;
            d.oe    = 1'b0;
            d.wrote = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (q.bitc < 4'(ACK_SLOT)) begin
                    d.sh   = byte_b;
                    d.bitc = q.bitc + 1'b1;
                    if (q.bitc == 4'(BITS_LAST)) begin
                        d.ack = 1'b1;
                        d.nxt = q.st;
                        case (q.st)
                            ST_DEV: begin
                                if ((code_main || code_id) && ce_hit) begin
                                    d.id  = code_id;
                                    d.nxt = byte_b[0] ? ST_RD : ST_AHI;
                                end else begin
                                    d.st  = ST_IDLE;
                                    d.ack = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                d.addr = ADDR_W'({byte_b, q.addr[7:0]});
                                d.nxt  = ST_ALO;
                            end
                            ST_ALO: begin
                                d.addr = {q.addr[ADDR_W-1:8], byte_b};
                                d.nxt  = ST_WR;
                            end
                            ST_WR: begin
                                if (wp_i) begin
                                    d.ack = 1'b0;
                                end else begin
                                    d.wdat  = byte_b;
                                    d.wstb  = 1'b1;
                                    d.wrote = 1'b1;
                                end
                            end
                            default: d.ack = 1'b0;
                        endcase
                    end
                end else if (q.bitc == 4'(ACK_SLOT)) begin
                    d.bitc = 4'(ACK_END);
                    if (q.st == ST_RD && sda_s) d.nxt = ST_IDLE;
                end
            end else if (scl_fall) begin
                if (q.bitc == 4'(ACK_SLOT)) begin
                    d.oe = q.ack;
                end else if (q.bitc == 4'(ACK_END)) begin
                    d.bitc = '0;
                    d.st   = q.nxt;
                    d.oe   = 1'b0;
                    if (q.nxt == ST_RD) begin
                        d.sh   = rd_data_i;
                        d.oe   = ~rd_data_i[7];
                        d.rreq = 1'b1;
                    end
                end else if (q.st == ST_RD && q.bitc != '0) begin
                    d.oe = ~q.sh[7];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.nxt <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign addr_o      = q.addr;
    assign wr_data_o   = q.wdat;
    assign wr_strobe_o = q.wstb;
    assign rd_req_o    = q.rreq;
    assign id_sel_o    = q.id;
    assign stop_o      = q.stp;
    assign commit_o    = q.cmt;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s_i,
    input logic              idle_i,
    input logic              sda_oe_o,
    input logic              wp_i,
    input logic              wr_busy_i,
    input logic              wr_strobe_o,
    input logic              rd_req_o,
    input logic              stop_o,
    input logic              commit_o,
    input logic [ADDR_W-1:0] addr_o
);
    assert_oe_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s_i);

    assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |-> !sda_oe_o);

    assert_wp_blocks_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_o |-> !$past(wp_i));

    assert_commit_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> stop_o);

    assert_addr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_strobe_o || rd_req_o) |-> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    assert_busy_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && wr_busy_i) |=> idle_i);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe_o, rd_req_o, stop_o}));
endmodule

bind i2c_mem_slave i2cs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s_i     (scl_s),
    .idle_i      (q.st == i2cs_pkg::ST_IDLE),
    .sda_oe_o    (sda_oe_o),
    .wp_i        (wp_i),
    .wr_busy_i   (wr_busy_i),
    .wr_strobe_o (wr_strobe_o),
    .rd_req_o    (rd_req_o),
    .stop_o      (stop_o),
    .commit_o    (commit_o),
    .addr_o      (addr_o)
);

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
    localparam int CLK_P = 10;
    localparam int H     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic        wp = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  rd_data;
    logic        sda_oe, wr_strobe, rd_req, id_sel, stop_p, commit_p;
    logic [14:0] addr;
    logic [7:0]  wr_data;
    wire         sda_line = ~(m_low | sda_oe);

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] model(input logic [14:0] a, input logic id);
        return a[7:0] ^ {1'b0, a[14:8]} ^ (id ? 8'hA5 : 8'h3C);
    endfunction

    assign rd_data = model(addr, id_sel);

    i2c_mem_slave u_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .ce_strap_i(strap), .wp_i(wp), .wr_busy_i(busy), .rd_data_i(rd_data),
        .sda_oe_o(sda_oe), .addr_o(addr), .wr_data_o(wr_data),
        .wr_strobe_o(wr_strobe), .rd_req_o(rd_req), .id_sel_o(id_sel),
        .stop_o(stop_p), .commit_o(commit_p)
    );

    // event logs
    logic [14:0] log_a [0:63];
    logic [7:0]  log_d [0:63];
    logic        log_i [0:63];
    int nw = 0, nstop = 0, ncmt = 0, nrd = 0, oe_viol = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe && nw < 64) begin
                log_a[nw] = addr; log_d[nw] = wr_data; log_i[nw] = id_sel;
            end
            if (wr_strobe) nw++;
            if (stop_p)   nstop++;
            if (commit_p) ncmt++;
            if (rd_req)   nrd++;
            if (scl && prev_scl && sda_oe && !prev_oe) oe_viol++;
            prev_scl = scl;
            prev_oe  = sda_oe;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_n(H/2); m_low = 1'b0;
        wait_n(H/2); scl = 1'b1;
        wait_n(H);   m_low = 1'b1;
        wait_n(H);   scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(H/2); m_low = 1'b1;
        wait_n(H/2); scl = 1'b1;
        wait_n(H);   m_low = 1'b0;
        wait_n(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_n(H/2); m_low = ~b[i];
            wait_n(H/2); scl = 1'b1;
            wait_n(H);   scl = 1'b0;
        end
        wait_n(H/2); m_low = 1'b0;
        wait_n(H/2); scl = 1'b1;
        wait_n(H/2); acked = ~sda_line;
        wait_n(H/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_n(H/2); m_low = 1'b0;
            wait_n(H/2); scl = 1'b1;
            wait_n(H/2); b[i] = sda_line;
            wait_n(H/2); scl = 1'b0;
        end
        wait_n(H/2); m_low = mack;
        wait_n(H/2); scl = 1'b1;
        wait_n(H);   scl = 1'b0;
    endtask

    initial begin
        wait_n(300000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        int base, c0, s0, r0;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        check("R12 reset oe", int'(sda_oe), 0);
        check("R12 reset strobes", int'({wr_strobe, rd_req, stop_p, commit_p}), 0);
        check("R12 reset addr", int'(addr), 0);

        // R3: strap versus select-byte chip-enable sweep
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 8; c++) begin
                strap = 3'(s);
                bus_start();
                send_byte({4'hA, 3'(c), 1'b0}, ack);
                check($sformatf("R3 ce s=%0d c=%0d", s, c), int'(ack), int'(s == c));
                if (s != c) begin
                    send_byte({4'hA, 3'(s), 1'b0}, ack);
                    check("R3 ignored after mismatch", int'(ack), 0);
                end
                bus_stop();
            end
        end
        strap = 3'b101;

        // R3 / R4: prefix sweep
        for (int p = 0; p < 16; p++) begin
            bus_start();
            send_byte({4'(p), strap, 1'b0}, ack);
            check($sformatf("R3 prefix %0h", p), int'(ack), int'(p == 10 || p == 11));
            bus_stop();
        end

        // R1 R2 R5 R6 R10: page write across wrap
        base = nw; c0 = ncmt; s0 = nstop;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack); check("R5 select ack", int'(ack), 1);
        send_byte(8'hFF, ack);               check("R5 addr hi ack", int'(ack), 1);
        send_byte(8'hFE, ack);               check("R5 addr lo ack", int'(ack), 1);
        send_byte(8'h96, ack);               check("R5 data ack", int'(ack), 1);
        send_byte(8'h3C, ack);               check("R5 data ack", int'(ack), 1);
        send_byte(8'hA5, ack);               check("R5 data ack", int'(ack), 1);
        bus_stop();
        wait_n(4);
        check("R5 strobe count", nw - base, 3);
        check("R5 addr0", int'(log_a[base]), 'h7FFE);
        check("R2 data0 msb first", int'(log_d[base]), 'h96);
        check("R6 addr1", int'(log_a[base+1]), 'h7FFF);
        check("R6 addr wrap", int'(log_a[base+2]), 'h0000);
        check("R2 data2", int'(log_d[base+2]), 'hA5);
        check("R4 main page", int'(log_i[base]), 0);
        check("R10 commit after write", ncmt - c0, 1);
        check("R1 stop pulse", nstop - s0, 1);

        // R4: identification page write
        base = nw;
        bus_start();
        send_byte({4'hB, strap, 1'b0}, ack); check("R4 id select ack", int'(ack), 1);
        send_byte(8'h00, ack);
        send_byte(8'h12, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        wait_n(4);
        check("R4 id strobe", nw - base, 1);
        check("R4 id flag", int'(log_i[base]), 1);
        check("R4 id addr", int'(log_a[base]), 'h12);

        // R7: write protect
        wp = 1'b1; base = nw; c0 = ncmt;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack); check("R7 select ack", int'(ack), 1);
        send_byte(8'h00, ack);               check("R7 addr hi ack", int'(ack), 1);
        send_byte(8'h40, ack);               check("R7 addr lo ack", int'(ack), 1);
        send_byte(8'h77, ack);               check("R7 data nack", int'(ack), 0);
        bus_stop();
        wait_n(4);
        check("R7 no strobe", nw - base, 0);
        check("R10 no commit when protected", ncmt - c0, 0);
        wp = 1'b0;

        // R8 R11: random read via repeated start
        c0 = ncmt; r0 = nrd;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack);
        send_byte(8'h01, ack);
        send_byte(8'h23, ack);
        bus_start();
        send_byte({4'hA, strap, 1'b1}, ack); check("R11 repeated start ack", int'(ack), 1);
        recv_byte(1'b1, rb); check("R8 read0", int'(rb), int'(model(15'h0123, 1'b0)));
        recv_byte(1'b1, rb); check("R8 read1", int'(rb), int'(model(15'h0124, 1'b0)));
        recv_byte(1'b0, rb); check("R8 read2", int'(rb), int'(model(15'h0125, 1'b0)));
        wait_n(2);
        check("R8 released after nack", int'(sda_oe), 0);
        bus_stop();
        wait_n(4);
        check("R8 fetch count", nrd - r0, 3);
        check("R10 no commit without data", ncmt - c0, 0);

        // R8 R6: current-address read continues
        bus_start();
        send_byte({4'hA, strap, 1'b1}, ack);
        recv_byte(1'b0, rb); check("R8 current read", int'(rb), int'(model(15'h0126, 1'b0)));
        bus_stop();

        // R4: identification page read
        bus_start();
        send_byte({4'hB, strap, 1'b1}, ack); check("R4 id read ack", int'(ack), 1);
        recv_byte(1'b0, rb); check("R4 id read data", int'(rb), int'(model(15'h0127, 1'b1)));
        bus_stop();

        // R9: busy ignores start
        busy = 1'b1; r0 = nrd;
        bus_start();
        send_byte({4'hA, strap, 1'b1}, ack); check("R9 busy no ack", int'(ack), 0);
        bus_stop();
        check("R9 busy no fetch", nrd - r0, 0);
        busy = 1'b0;
        bus_start();
        send_byte({4'hA, strap, 1'b0}, ack); check("R9 ack after busy", int'(ack), 1);
        bus_stop();

        check("R12 oe rose while clock high", oe_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule